// File: doc/BRIEF.md
# MAC-PHY Sideband Controller

This block connects a MAC register file to an integrated PHY through the signals that run outside the data path. It drives a reset into the PHY. The reset is active when the bus reset is active or when software sets a PHY-reset control bit. The PHY's raw link, duplex and speed indications pass through two-flop synchronizers and are then presented as MAC status bits.

When software forces speed and duplex, the status bits show the forced values instead of the PHY's values. Any change in link state sets a sticky interrupt cause. Software clears this cause by writing one to a clear bit, and an enable bit masks it onto the interrupt line. A rising link produces a one-cycle resync pulse, which lets the MAC reload its speed and duplex configuration. The MAC's power state goes to the PHY only when PHY power management is enabled; otherwise the PHY sees D0.

Top module: `phy_sideband`

## Requirements
- R1: `phy_rst_n` is low whenever `rst_n` is low or `ctl_phy_rst` is 1. When both inputs are inactive it is high.
- R2: `st_link` equals the value `phy_link` had two clock edges earlier (two-flop synchronizer).
- R3: A change of `st_link` between two cycles sets `lsc_cause` at the next edge. The bit stays set until `lsc_clr` is 1 at an edge, and a new change in that same cycle wins over the clear. Because the synchronizer flops reset to 0, a link that is already up when reset is released counts as a change.
- R4: `irq` is 1 exactly when `lsc_cause` is 1 and `ctl_lsc_ie` is 1.
- R5: With `ctl_force` at 0, `st_fd` follows the synchronized `phy_fd`. With `ctl_force` at 1, `st_fd` equals `ctl_force_fd` at once (1 means full duplex).
- R6: Speed codes are 00 for 10 Mb/s, 01 for 100 Mb/s and 10 for 1000 Mb/s. The reserved code 11 is reported as 10. `st_spd` shows the synchronized `phy_spd` when `ctl_force` is 0 and `ctl_force_spd` when it is 1. Every duplex and speed combination, including half duplex at 1000 Mb/s, passes through.
- R7: `phy_pwr` equals `mac_pwr` (00=D0 … 11=D3) when `ctl_pm_en` is 1, and 00 (D0) otherwise.
- R8: `resync` is high for exactly one cycle, in the first cycle `st_link` reads 1 after reading 0. It never pulses on a falling link.
- R9: While `rst_n` is low, `st_link`, `lsc_cause`, `irq` and `resync` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Bus reset, active low, asynchronous |
| ctl_phy_rst | input | 1 | Software PHY reset bit |
| ctl_force | input | 1 | Force speed and duplex from control bits |
| ctl_force_fd | input | 1 | Forced duplex, 1 = full |
| ctl_force_spd | input | 2 | Forced speed code |
| ctl_pm_en | input | 1 | Enable passing power state to PHY |
| ctl_lsc_ie | input | 1 | Link-change interrupt enable |
| lsc_clr | input | 1 | Write-one-to-clear strobe for the cause bit |
| mac_pwr | input | 2 | MAC power state D0..D3 |
| phy_link | input | 1 | Raw PHY link indication |
| phy_fd | input | 1 | Raw PHY full-duplex indication |
| phy_spd | input | 2 | Raw PHY speed indication |
| phy_rst_n | output | 1 | Reset to PHY, active low |
| st_link | output | 1 | Link-up status |
| st_fd | output | 1 | Duplex status |
| st_spd | output | 2 | Speed status |
| lsc_cause | output | 1 | Sticky link-change cause |
| irq | output | 1 | Masked link-change interrupt |
| resync | output | 1 | One-cycle pulse on link up |
| phy_pwr | output | 2 | Power state seen by PHY |

## Verification
A software clear of the cause bit and a new link change can land on the same edge. The bench lets the cause become set, then toggles the link. It raises `lsc_clr` in exactly the cycle where the synchronized link differs from its previous sample, and expects the cause to stay set. It then expects a later clear with no change to drop the cause. The force and power selections are swept over every combination of control and PHY codes, and each status value is compared against the selection computed in the bench.

// File: rtl/phy_sideband.sv
module phy_sideband (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_phy_rst,
  input  logic       ctl_force,
  input  logic       ctl_force_fd,
  input  logic [1:0] ctl_force_spd,
  input  logic       ctl_pm_en,
  input  logic       ctl_lsc_ie,
  input  logic       lsc_clr,
  input  logic [1:0] mac_pwr,
  input  logic       phy_link,
  input  logic       phy_fd,
  input  logic [1:0] phy_spd,
  output logic       phy_rst_n,
  output logic       st_link,
  output logic       st_fd,
  output logic [1:0] st_spd,
  output logic       lsc_cause,
  output logic       irq,
  output logic       resync,
  output logic [1:0] phy_pwr
);
  localparam int W = 4;

  logic [W-1:0] s1, s2;
  logic         link_q;
  logic [1:0]   spd_sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1     <= '0;
      s2     <= '0;
      link_q <= 1'b0;
    end else begin
      s1     <= {phy_spd, phy_fd, phy_link};
      s2     <= s1;
      link_q <= s2[0];
    end

  assign st_link = s2[0];
  wire   chg     = s2[0] ^ link_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       lsc_cause <= 1'b0;
    else if (chg)     lsc_cause <= 1'b1;
    else if (lsc_clr) lsc_cause <= 1'b0;

  assign irq       = lsc_cause & ctl_lsc_ie;
  assign resync    = s2[0] & ~link_q;
  assign phy_rst_n = rst_n & ~ctl_phy_rst;

  assign st_fd   = ctl_force ? ctl_force_fd : s2[1];
  assign spd_sel = ctl_force ? ctl_force_spd : s2[3:2];
  assign st_spd  = (spd_sel == 2'b11) ? 2'b10 : spd_sel;

  assign phy_pwr = ctl_pm_en ? mac_pwr : 2'b00;
endmodule

module phy_sideband_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_phy_rst,
  input logic       ctl_pm_en,
  input logic       ctl_lsc_ie,
  input logic       lsc_clr,
  input logic       phy_rst_n,
  input logic       st_link,
  input logic [1:0] st_spd,
  input logic       lsc_cause,
  input logic       irq,
  input logic       resync,
  input logic [1:0] phy_pwr
);
  a_r1_sw_reset: assert property (@(posedge clk) ctl_phy_rst |-> !phy_rst_n);
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lsc_cause && !lsc_clr |=> lsc_cause);
  a_r3_cause_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lsc_cause) |-> $past(st_link) != $past(st_link, 2));
  a_r4_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> lsc_cause && ctl_lsc_ie);
  a_r6_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    st_spd != 2'b11);
  a_r7_pwr_d0: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_pm_en |-> phy_pwr == 2'b00);
  a_r8_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
    resync |-> st_link && !$past(st_link));
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !resync);
endmodule

bind phy_sideband phy_sideband_chk i_chk (.*);

// File: tb/test_phy_sideband.sv
module test_phy_sideband;
  logic clk = 0, rst_n = 0;
  logic ctl_phy_rst = 0, ctl_force = 0, ctl_force_fd = 0, ctl_pm_en = 0;
  logic ctl_lsc_ie = 0, lsc_clr = 0, phy_link = 0, phy_fd = 0;
  logic [1:0] ctl_force_spd = 0, mac_pwr = 0, phy_spd = 0;
  logic phy_rst_n, st_link, st_fd, lsc_cause, irq, resync;
  logic [1:0] st_spd, phy_pwr;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  phy_sideband i_phy_sideband (.*);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R9 reset state, R1 reset merge
    phy_link = 1;
    tick(2);
    chk("R9 link", st_link, 0);
    chk("R9 cause", lsc_cause, 0);
    chk("R9 irq", irq, 0);
    chk("R9 resync", resync, 0);
    for (int b = 0; b < 4; b++) begin
      rst_n = b[0]; ctl_phy_rst = b[1]; #1;
      chk("R1 phy_rst_n", phy_rst_n, (b[0] && !b[1]) ? 1 : 0);
    end
    // R3 link up at reset release counts as change; R2, R8
    rst_n = 1; ctl_phy_rst = 0; ctl_lsc_ie = 0;
    tick(2);
    chk("R2 link after sync", st_link, 1);
    chk("R8 resync pulse", resync, 1);
    chk("R4 irq masked", irq, 0);
    tick(1);
    chk("R8 resync ends", resync, 0);
    chk("R3 cause set at release", lsc_cause, 1);
    ctl_lsc_ie = 1; #1;
    chk("R4 irq enabled", irq, 1);
    lsc_clr = 1; tick(1); lsc_clr = 0;
    chk("R3 clear", lsc_cause, 0);
    chk("R4 irq after clear", irq, 0);
    // R2 sync latency, falling link without resync
    phy_link = 0;
    tick(1);
    chk("R2 not yet", st_link, 1);
    tick(1);
    chk("R2 fell", st_link, 0);
    chk("R8 no pulse on fall", resync, 0);
    tick(1);
    chk("R3 cause on fall", lsc_cause, 1);
    tick(3);
    chk("R3 sticky", lsc_cause, 1);
    // R3 clear and new change in the same cycle
    phy_link = 1;
    tick(2);
    chk("R8 pulse on rise", resync, 1);
    lsc_clr = 1; tick(1); lsc_clr = 0;
    chk("R3 set beats clear", lsc_cause, 1);
    chk("R8 single cycle", resync, 0);
    lsc_clr = 1; tick(1); lsc_clr = 0;
    chk("R3 clear alone", lsc_cause, 0);
    // R5 R6 sweep
    for (int f = 0; f < 2; f++)
      for (int ffd = 0; ffd < 2; ffd++)
        for (int fs = 0; fs < 4; fs++)
          for (int pfd = 0; pfd < 2; pfd++)
            for (int ps = 0; ps < 4; ps++) begin
              ctl_force = f[0]; ctl_force_fd = ffd[0]; ctl_force_spd = fs[1:0];
              phy_fd = pfd[0]; phy_spd = ps[1:0];
              tick(2);
              chk("R5 duplex", st_fd, f ? ffd : pfd);
              chk("R6 speed", st_spd, (f ? fs : ps) == 3 ? 2 : (f ? fs : ps));
            end
    // R5 force takes effect without delay
    ctl_force = 0; phy_fd = 0; tick(2);
    ctl_force = 1; ctl_force_fd = 1; #1;
    chk("R5 immediate force", st_fd, 1);
    // R7 power sweep
    for (int e = 0; e < 2; e++)
      for (int p = 0; p < 4; p++) begin
        ctl_pm_en = e[0]; mac_pwr = p[1:0]; #1;
        chk("R7 power", phy_pwr, e ? p : 0);
      end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule